// File: doc/BRIEF.md
# Bit-Banged DDC GPIO Register

This block is one 32-bit register that lets software run a two-wire display data channel (I2C) bus by toggling pins by hand. For each of the clock line (SCL) and the data line (SDA), a write gives a data bit and a separate output-enable bit. The pads are open-drain. A line is pulled low only when its enable is set and its data bit is zero. Otherwise the line is released and the external pull-up takes it high. The real level of each line goes through a synchroniser and shows up in two readback bits, one byte above the drive bits.

A `BIT_BASE` parameter sets where the drive, enable and readback fields sit, so the same logic can occupy bit 0 of one register or bit 1 of another. A `GATED` parameter selects the variant used in a shared register. In that variant, many byte-wide writes reach the register. The pads only change on a write that covers the trigger byte while the gate bit is set. Other bytes can then be written without producing spurious bus edges. Bits outside the line fields are plain storage.

Top module: `ddc_gpio_reg`

## Requirements
- R1: While reset is asserted and after it is released, both pull-low outputs are 0 (lines released). The read value is 0 except the two readback bits, which read 1 (idle-high lines).
- R2: A write updates only the bytes whose byte enable is set. All stored bits other than the two readback bits read back exactly as last written.
- R3: The SDA pull-low output is 1 exactly when the SDA enable bit (BIT_BASE+16) is 1 and the SDA data bit (BIT_BASE) is 0, as taken from the register value of the last pad update.
- R4: The SCL pull-low output is 1 exactly when the SCL enable bit (BIT_BASE+17) is 1 and the SCL data bit (BIT_BASE+1) is 0, as taken from the register value of the last pad update.
- R5: A pad update takes effect at the clock edge that accepts the write. With no write accepted, the pull-low outputs hold.
- R6: Bit BIT_BASE+8 reads the SDA line level and bit BIT_BASE+9 reads the SCL line level, each delayed by two flops. Writes to these two bits have no effect.
- R7: With GATED=1, a write updates the pads only when its byte enable for byte 2 is set and bit 25 of the register value after the write is 1. Any other write leaves the pull-low outputs unchanged.
- R8: With GATED=0, every accepted write updates the pads. With BIT_BASE=1, every field moves up by one bit: data at 1/2, enables at 17/18, readback at 9/10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read value with live readback bits |
| sda_in | input | 1 | SDA pad level |
| scl_in | input | 1 | SCL pad level |
| sda_pull_low | output | 1 | 1 pulls the SDA pad low, 0 releases it |
| scl_pull_low | output | 1 | 1 pulls the SCL pad low, 0 releases it |

## Verification
The hardest case to reach is the gated variant's partial write. Here the gate bit that decides the pad update may come from the new write data or from the old stored byte, depending on which byte enables are set. The bench first makes the gate bit true with a full write. It then sweeps all sixteen byte-enable patterns with a value that would pull both lines low, so that only the byte-2 enable decides whether the pads move. A final write clears the gate and checks that already-driven lines stay low. For the ungated variant, the bench sweeps every combination of the four data and enable bits. It also pulls a released line low from outside to show the readback follows the wire and not the drive bits.

// File: rtl/ddc_gpio_pkg.sv
package ddc_gpio_pkg;

  // Expand byte enables into a bit mask
  function automatic logic [31:0] be_to_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) begin
      m[b*8 +: 8] = {8{be[b]}};
    end
    return m;
  endfunction

  // Index of each picked field in the compact field vector
  localparam int F_SDA_D = 0;
  localparam int F_SCL_D = 1;
  localparam int F_SDA_E = 2;
  localparam int F_SCL_E = 3;
  localparam int F_GATE  = 4;
  localparam int F_W     = 5;

endpackage

// File: rtl/ddc_byte_store.sv
module ddc_byte_store
  import ddc_gpio_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int BIT_BASE = 0,
  parameter int GATE_BIT = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W/8-1:0] wr_be,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   store_q,
  output logic [F_W-1:0]     fields_nxt
);

  localparam logic [REG_W-1:0] RB_MASK = (REG_W'(1) << (BIT_BASE + 8)) |
                                         (REG_W'(1) << (BIT_BASE + 9));

  logic [REG_W-1:0] store_d;
  logic [REG_W-1:0] merged;

  always_comb begin
    merged  = (store_q & ~be_to_mask(wr_be)) | (wr_data & be_to_mask(wr_be));
    store_d = merged & ~RB_MASK;
    fields_nxt[F_SDA_D] = merged[BIT_BASE];
    fields_nxt[F_SCL_D] = merged[BIT_BASE + 1];
    fields_nxt[F_SDA_E] = merged[BIT_BASE + 16];
    fields_nxt[F_SCL_E] = merged[BIT_BASE + 17];
    fields_nxt[F_GATE]  = merged[GATE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (wr_en) begin
      store_q <= store_d;
    end
  end

endmodule

// File: rtl/ddc_line_sync.sv
module ddc_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_sync
);

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pad_in[l]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign pad_sync[l] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ddc_pad_drive.sv
module ddc_pad_drive
  import ddc_gpio_pkg::*;
#(
  parameter bit GATED = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           trig_be,
  input  logic [F_W-1:0] fields_nxt,
  output logic           sda_pull_low,
  output logic           scl_pull_low
);

  logic upd_en;
  logic sda_low_d;
  logic scl_low_d;

  always_comb begin
    upd_en    = wr_en & (GATED ? (trig_be & fields_nxt[F_GATE]) : 1'b1);
    sda_low_d = fields_nxt[F_SDA_E] & ~fields_nxt[F_SDA_D];
    scl_low_d = fields_nxt[F_SCL_E] & ~fields_nxt[F_SCL_D];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_pull_low <= 1'b0;
      scl_pull_low <= 1'b0;
    end else if (upd_en) begin
      sda_pull_low <= sda_low_d;
      scl_pull_low <= scl_low_d;
    end
  end

endmodule

// File: rtl/ddc_gpio_reg.sv
module ddc_gpio_reg
  import ddc_gpio_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int BIT_BASE    = 0,
  parameter bit GATED       = 1'b0,
  parameter int GATE_BIT    = 25,
  parameter int TRIG_BYTE   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W/8-1:0] wr_be,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic               sda_in,
  input  logic               scl_in,
  output logic               sda_pull_low,
  output logic               scl_pull_low
);

  localparam int RB_SDA = BIT_BASE + 8;
  localparam int RB_SCL = BIT_BASE + 9;

  logic [REG_W-1:0] store_q;
  logic [F_W-1:0]   fields_nxt;
  logic [1:0]       line_sync;

  ddc_byte_store #(
    .REG_W   (REG_W),
    .BIT_BASE(BIT_BASE),
    .GATE_BIT(GATE_BIT)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .store_q   (store_q),
    .fields_nxt(fields_nxt)
  );

  ddc_pad_drive #(
    .GATED(GATED)
  ) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .trig_be     (wr_be[TRIG_BYTE]),
    .fields_nxt  (fields_nxt),
    .sda_pull_low(sda_pull_low),
    .scl_pull_low(scl_pull_low)
  );

  ddc_line_sync #(
    .LINES (2),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  ({scl_in, sda_in}),
    .pad_sync(line_sync)
  );

  always_comb begin
    rd_data         = store_q;
    rd_data[RB_SDA] = line_sync[0];
    rd_data[RB_SCL] = line_sync[1];
  end

endmodule

// File: rtl/ddc_gpio_chk.sv
module ddc_gpio_chk #(
  parameter bit GATED = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_trig_be,
  input logic wr_gate_be,
  input logic wr_gate_d,
  input logic rd_gate,
  input logic rd_sda_d,
  input logic rd_scl_d,
  input logic rd_sda_e,
  input logic rd_scl_e,
  input logic rd_sda_rb,
  input logic rd_scl_rb,
  input logic sda_in,
  input logic scl_in,
  input logic sda_pull_low,
  input logic scl_pull_low
);

  logic [1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= '0;
    end else if (up_cnt != 2'd3) begin
      up_cnt <= up_cnt + 2'd1;
    end
  end

  // R1
  reset_release_chk: assert property (@(posedge clk)
    !rst_n |-> (!sda_pull_low && !scl_pull_low));

  // R3
  sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !GATED |-> (sda_pull_low == (rd_sda_e && !rd_sda_d)));

  // R4
  scl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !GATED |-> (scl_pull_low == (rd_scl_e && !rd_scl_d)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(sda_pull_low) && $stable(scl_pull_low)));

  // R6
  sda_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> (rd_sda_rb == $past(sda_in, 2)));

  // R6
  scl_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> (rd_scl_rb == $past(scl_in, 2)));

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GATED && wr_en && !(wr_trig_be && (wr_gate_be ? wr_gate_d : rd_gate)))
    |=> ($stable(sda_pull_low) && $stable(scl_pull_low)));

endmodule

bind ddc_gpio_reg ddc_gpio_chk #(
  .GATED(GATED)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_trig_be  (wr_be[TRIG_BYTE]),
  .wr_gate_be  (wr_be[GATE_BIT/8]),
  .wr_gate_d   (wr_data[GATE_BIT]),
  .rd_gate     (rd_data[GATE_BIT]),
  .rd_sda_d    (rd_data[BIT_BASE]),
  .rd_scl_d    (rd_data[BIT_BASE+1]),
  .rd_sda_e    (rd_data[BIT_BASE+16]),
  .rd_scl_e    (rd_data[BIT_BASE+17]),
  .rd_sda_rb   (rd_data[BIT_BASE+8]),
  .rd_scl_rb   (rd_data[BIT_BASE+9]),
  .sda_in      (sda_in),
  .scl_in      (scl_in),
  .sda_pull_low(sda_pull_low),
  .scl_pull_low(scl_pull_low)
);

// File: tb/sim_ddc_gpio_reg.sv
`timescale 1ns/1ps
module sim_ddc_gpio_reg;

  logic        clk;
  logic        rst_n;
  logic        w0_en, w1_en;
  logic [3:0]  w0_be, w1_be;
  logic [31:0] w0_data, w1_data;
  logic [31:0] rd0, rd1;
  logic        sda0_low, scl0_low, sda1_low, scl1_low;
  logic        ext_sda0;
  logic        sda0_line, scl0_line, sda1_line, scl1_line;

  int total = 0;
  int bad   = 0;
  logic [31:0] m0, m1;

  assign sda0_line = ~(sda0_low | ext_sda0);
  assign scl0_line = ~scl0_low;
  assign sda1_line = ~sda1_low;
  assign scl1_line = ~scl1_low;

  ddc_gpio_reg #(.BIT_BASE(0), .GATED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(w0_en), .wr_be(w0_be), .wr_data(w0_data),
    .rd_data(rd0), .sda_in(sda0_line), .scl_in(scl0_line),
    .sda_pull_low(sda0_low), .scl_pull_low(scl0_low));

  ddc_gpio_reg #(.BIT_BASE(1), .GATED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(w1_en), .wr_be(w1_be), .wr_data(w1_data),
    .rd_data(rd1), .sda_in(sda1_line), .scl_in(scl1_line),
    .sda_pull_low(sda1_low), .scl_pull_low(scl1_low));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] bmask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Writes are applied at a falling edge, accepted at the next rising edge
  task automatic wr0(input logic [3:0] be, input logic [31:0] d);
    w0_en = 1'b1; w0_be = be; w0_data = d;
    @(negedge clk);
    w0_en = 1'b0;
    m0 = ((m0 & ~bmask(be)) | (d & bmask(be))) & ~32'h0000_0300;
  endtask

  task automatic wr1(input logic [3:0] be, input logic [31:0] d);
    w1_en = 1'b1; w1_be = be; w1_data = d;
    @(negedge clk);
    w1_en = 1'b0;
    m1 = ((m1 & ~bmask(be)) | (d & bmask(be))) & ~32'h0000_0600;
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic esda, escl, old_sda;
    logic [31:0] d;
    bit trig;
    rst_n = 1'b0; w0_en = 0; w1_en = 0; w0_be = 0; w1_be = 0;
    w0_data = 0; w1_data = 0; ext_sda0 = 0; m0 = 0; m1 = 0;
    repeat (3) @(negedge clk);
    // R1: in reset
    check("R1 u0 pulls", {30'd0, sda0_low, scl0_low}, 32'd0);
    check("R1 u1 pulls", {30'd0, sda1_low, scl1_low}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 u0 read", rd0, 32'h0000_0300);
    check("R1 u1 read", rd1, 32'h0000_0600);

    // R3 R4 R5 R6: all data/enable combinations, ungated base 0
    for (int v = 0; v < 16; v++) begin
      d = {14'd0, v[3], v[2], 14'd0, v[1], v[0]};
      old_sda = sda0_line;
      wr0(4'hF, d);
      esda = v[2] & ~v[0];
      escl = v[3] & ~v[1];
      check("R3 sda pull", {31'd0, sda0_low}, {31'd0, esda});
      check("R4 scl pull", {31'd0, scl0_low}, {31'd0, escl});
      @(negedge clk);
      check("R6 sda sync delay", {31'd0, rd0[8]}, {31'd0, old_sda});
      @(negedge clk);
      check("R6 u0 readback", rd0, m0 | {22'd0, ~escl, ~esda, 8'd0});
      repeat (2) @(negedge clk);
      check("R5 hold", {30'd0, sda0_low, scl0_low}, {30'd0, esda, escl});
    end

    // R6: readback follows the wire, not the drive bits
    wr0(4'hF, 32'h0000_0000);
    ext_sda0 = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 external low", rd0, 32'h0000_0200);
    ext_sda0 = 1'b0;
    repeat (2) @(negedge clk);
    // R6 R2: writes to readback bits ignored, other bits stored
    wr0(4'hF, 32'hFFFF_FCFF);
    repeat (2) @(negedge clk);
    check("R2 R6 all ones", rd0, 32'hFFFF_FFFF);
    wr0(4'hF, 32'h0000_0000);
    repeat (2) @(negedge clk);
    check("R6 readback not stored", rd0, 32'h0000_0300);

    // R2: byte-enable sweep
    for (int be = 0; be < 16; be++) begin
      wr0(4'hF, 32'h0000_0000);
      wr0(be[3:0], 32'hA5C3_5A3C);
      esda = m0[16] & ~m0[0];
      escl = m0[17] & ~m0[1];
      repeat (2) @(negedge clk);
      check("R2 byte enables", rd0, m0 | {22'd0, ~escl, ~esda, 8'd0});
    end

    // R7 R8: gated variant at base 1, all byte-enable patterns
    for (int be = 0; be < 16; be++) begin
      wr1(4'hF, 32'h0200_0000);
      check("R7 release", {30'd0, sda1_low, scl1_low}, 32'd0);
      wr1(be[3:0], 32'h0206_0000);
      trig = be[2] && m1[25];
      check("R7 partial write", {30'd0, sda1_low, scl1_low}, {30'd0, trig, trig});
    end
    // gate cleared by the same write: no pad update
    wr1(4'hF, 32'h0200_0000);
    wr1(4'hC, 32'h0006_0000);
    check("R7 gate clear", {30'd0, sda1_low, scl1_low}, 32'd0);
    // drive both low, then clear gate with a full write: lines stay low
    wr1(4'hF, 32'h0206_0000);
    check("R8 base1 drive", {30'd0, sda1_low, scl1_low}, 32'd3);
    wr1(4'hF, 32'h0000_0000);
    check("R7 hold low", {30'd0, sda1_low, scl1_low}, 32'd3);
    repeat (2) @(negedge clk);
    check("R8 base1 readback", rd1, 32'h0000_0000);
    // release with gate, readback at bits 9/10
    wr1(4'hF, 32'h0206_0006);
    repeat (2) @(negedge clk);
    check("R8 base1 released", rd1, 32'h0206_0606);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule